// File: doc/BRIEF.md
# Synchronous Burst Read Sequencer

This block is the read-side controller of a memory that delivers data in clocked bursts. One 16-bit configuration word sets it up. That word selects:

- synchronous or asynchronous operation;
- the first-access latency;
- the spacing between later beats;
- when the active-low valid strobe appears;
- interleaved or sequential word order;
- whether the burst wraps at its block boundary;
- the burst length;
- which clock edge presents the data.

When the address-latch strobe rises, the block captures the start address. It counts out the first-access latency and then steps through the word addresses of the burst. For each beat it registers the word that the memory array returns for the current address. A single datapath therefore produces patterns such as 4-1-1-1, 5-2-2-2 or 8-1-1-1.

The strobe is level-sensitive. A burst lasts only while the strobe stays high. A continuous burst keeps counting upward until the strobe falls. Latency or length codes outside the supported set are refused and recorded in a sticky error flag.

Top module: `burst_rd_seq`

## Requirements
- R1: After reset the block is in asynchronous mode (configuration bit 15 = 1). In that mode a rising latch strobe is ignored: `valid_n` stays 1, `rd_data` stays 0 and `mem_addr` stays 0. The reset configuration also holds latency 4, one-cycle spacing, normal valid timing, interleaved order, falling edge, wrap and length 4.
- R2: With bit 15 = 0, bits 13:11 give the first-access latency L (010=4, 011=5, 100=6, 101=7, 110=8 cycles). If the strobe is first seen high at clock edge T0, the first beat's data is registered at edge T0+L.
- R3: A write whose latency code (bits 13:11 = 000, 001, 111) or length code (bits 2:0 not 001, 010, 111) is unsupported leaves that field unchanged. It still updates every other field and sets `cfg_err`, which stays 1 until reset.
- R4: Bit 9 sets the beat spacing S: 0 gives one cycle per beat and 1 gives two. Beat k is registered at edge T0+L+k·S.
- R5: Bit 8 = 0 drives `valid_n` low for exactly the cycle that follows each beat edge. Bit 8 = 1 drives it low for the cycle one clock earlier.
- R6: Bit 7 = 0 selects interleaved order. For burst length N and start offset s = start mod N, beat k addresses (start − s) + (s XOR k). Bit 7 = 1 selects sequential order.
- R7: In sequential order, bit 3 = 0 wraps within the N-word block: (start − s) + ((s + k) mod N). Bit 3 = 1 gives start + k. In interleaved order bit 3 has no effect.
- R8: Bits 2:0 set the length: 001 gives 4 beats and 010 gives 8. After the last beat, `valid_n` stays 1 and `mem_addr` holds the final beat's address.
- R9: Length code 111 is continuous: beat k addresses start + k in either order, and beats continue while the strobe stays high. When the strobe is seen low at an edge, no further beats occur.
- R10: Bit 6 = 1 presents new data on `rd_data` at the beat's rising edge. Bit 6 = 0 presents it half a cycle later, at the following falling edge.
- R11: At each beat `rd_data` takes the `mem_rdata` word returned for the current `mem_addr`. It holds that value until the next beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration write enable |
| cfg_wdata | input | 16 | Configuration word |
| addr_latch | input | 1 | Address-latch strobe; rising edge starts a burst, low ends it |
| start_addr | input | AW | Burst start word address |
| mem_addr | output | AW | Current word address to the memory array |
| mem_rdata | input | DW | Word read from the memory array at `mem_addr` |
| rd_data | output | DW | Burst data |
| valid_n | output | 1 | Active-low data-valid strobe |
| cfg_err | output | 1 | Sticky flag for unsupported latency or length codes |

## Verification
A wrong beat delay or a wrong spacing count shows up on `valid_n` at the very first beat. It appears as a strobe that is one or more cycles early or late against the edge predicted from the latch cycle. A fault in the beat index or the order logic appears on `mem_addr` one clock after the beat where it occurs, and on `rd_data` at the following beat. A configuration field that was stored wrongly affects every beat of the next burst. For that reason every combination of latency, spacing, order, wrap and length is run, with each beat compared on every clock.

// File: rtl/burst_pkg.sv
package burst_pkg;

  typedef struct packed {
    logic       async;
    logic [2:0] lat;
    logic       space2;
    logic       early;
    logic       seq;
    logic       rise;
    logic       nowrap;
    logic [2:0] len;
  } burst_cfg_t;

  localparam logic [2:0] LEN_4    = 3'b001;
  localparam logic [2:0] LEN_8    = 3'b010;
  localparam logic [2:0] LEN_CONT = 3'b111;

  localparam int CFG_W = 16;

  function automatic logic lat_ok(input logic [2:0] c);
    return (c >= 3'b010) && (c <= 3'b110);
  endfunction

  function automatic logic len_ok(input logic [2:0] c);
    return (c == LEN_4) || (c == LEN_8) || (c == LEN_CONT);
  endfunction

  // Reload value of the delay counter: latency minus one (code + 1).
  function automatic logic [2:0] lat_reload(input logic [2:0] c);
    return c + 3'd1;
  endfunction

  // Block mask, N-1.
  function automatic logic [2:0] len_mask(input logic [2:0] c);
    return (c == LEN_8) ? 3'b111 : 3'b011;
  endfunction

endpackage

// File: rtl/burst_cfg_reg.sv
module burst_cfg_reg
  import burst_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [CFG_W-1:0]    wdata,
  output burst_cfg_t          cfg,
  output logic                err
);

  burst_cfg_t cfg_q, cfg_d;
  logic       err_q, err_d;

  always_comb begin
    cfg_d = cfg_q;
    err_d = err_q;
    if (we) begin
      cfg_d.async  = wdata[15];
      cfg_d.space2 = wdata[9];
      cfg_d.early  = wdata[8];
      cfg_d.seq    = wdata[7];
      cfg_d.rise   = wdata[6];
      cfg_d.nowrap = wdata[3];
      if (lat_ok(wdata[13:11])) cfg_d.lat = wdata[13:11];
      else                      err_d = 1'b1;
      if (len_ok(wdata[2:0]))   cfg_d.len = wdata[2:0];
      else                      err_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.async  <= 1'b1;
      cfg_q.lat    <= 3'b010;
      cfg_q.space2 <= 1'b0;
      cfg_q.early  <= 1'b0;
      cfg_q.seq    <= 1'b0;
      cfg_q.rise   <= 1'b0;
      cfg_q.nowrap <= 1'b0;
      cfg_q.len    <= LEN_4;
      err_q        <= 1'b0;
    end else if (we) begin
      cfg_q <= cfg_d;
      err_q <= err_d;
    end
  end

  assign cfg = cfg_q;
  assign err = err_q;

endmodule

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  burst_cfg_t  cfg,
  input  logic        latch_in,
  output logic        load,
  output logic        active,
  output logic        fire,
  output logic        pre,
  output logic        last,
  output logic [2:0]  beat_k
);

  logic       active_q, active_d;
  logic [2:0] dly_q, dly_d;
  logic [2:0] k_q, k_d;
  logic       latch_q;
  logic       sync_mode, cont, last_pending, rise_evt;

  assign sync_mode    = ~cfg.async;
  assign cont         = (cfg.len == LEN_CONT);
  assign rise_evt     = latch_in & ~latch_q;
  assign load         = rise_evt & sync_mode;
  assign last_pending = ~cont & (k_q == len_mask(cfg.len));
  assign fire         = active_q & latch_in & sync_mode & (dly_q == 3'd0);
  assign last         = fire & last_pending;
  assign pre          = active_q & latch_in & sync_mode &
                        ((dly_q == 3'd1) |
                         ((dly_q == 3'd0) & ~cfg.space2 & ~last_pending));

  always_comb begin
    active_d = active_q;
    dly_d    = dly_q;
    k_d      = k_q;
    if (load) begin
      active_d = 1'b1;
      dly_d    = lat_reload(cfg.lat);
      k_d      = 3'd0;
    end else if (active_q && (!latch_in || !sync_mode)) begin
      active_d = 1'b0;
    end else if (fire) begin
      if (last_pending) begin
        active_d = 1'b0;
      end else begin
        k_d   = k_q + 3'd1;
        dly_d = cfg.space2 ? 3'd1 : 3'd0;
      end
    end else if (active_q && dly_q != 3'd0) begin
      dly_d = dly_q - 3'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      dly_q    <= 3'd0;
      k_q      <= 3'd0;
      latch_q  <= 1'b0;
    end else begin
      active_q <= active_d;
      dly_q    <= dly_d;
      k_q      <= k_d;
      latch_q  <= latch_in;
    end
  end

  assign active = active_q;
  assign beat_k = k_q;

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  burst_cfg_t    cfg,
  input  logic          load,
  input  logic          fire,
  input  logic          last,
  input  logic [2:0]    beat_k,
  input  logic [AW-1:0] start_addr,
  output logic [AW-1:0] start_q,
  output logic [AW-1:0] addr
);

  localparam int OFFW = 3;

  logic [AW-1:0]   addr_q, addr_d, start_r, start_d;
  logic [AW-1:0]   mask_w, base, linear;
  logic [OFFW-1:0] mask3, kn, off_seq, off_int;
  logic            use_linear;

  assign mask3 = len_mask(cfg.len);

  genvar gi;
  generate
    for (gi = 0; gi < AW; gi++) begin : g_mask
      if (gi < OFFW) begin : g_lo
        assign mask_w[gi] = mask3[gi];
      end else begin : g_hi
        assign mask_w[gi] = 1'b0;
      end
    end
  endgenerate

  assign kn         = beat_k + 3'd1;
  assign base       = start_r & ~mask_w;
  assign linear     = addr_q + {{(AW-1){1'b0}}, 1'b1};
  assign off_seq    = (start_r[OFFW-1:0] + kn) & mask3;
  assign off_int    = (start_r[OFFW-1:0] ^ kn) & mask3;
  assign use_linear = (cfg.len == LEN_CONT) | (cfg.seq & cfg.nowrap);

  always_comb begin
    addr_d  = addr_q;
    start_d = start_r;
    if (load) begin
      addr_d  = start_addr;
      start_d = start_addr;
    end else if (fire && !last) begin
      if (use_linear)   addr_d = linear;
      else if (cfg.seq) addr_d = base | {{(AW-OFFW){1'b0}}, off_seq};
      else              addr_d = base | {{(AW-OFFW){1'b0}}, off_int};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      start_r <= '0;
    end else if (load || fire) begin
      addr_q  <= addr_d;
      start_r <= start_d;
    end
  end

  assign addr    = addr_q;
  assign start_q = start_r;

endmodule

// File: rtl/burst_out_stage.sv
module burst_out_stage
  import burst_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  burst_cfg_t    cfg,
  input  logic          fire,
  input  logic          pre,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] rd_data,
  output logic          valid_n
);

  logic [DW-1:0] rd_pos_q, rd_neg_q;
  logic          vld_q, vld_d;

  assign vld_d = cfg.early ? pre : fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pos_q <= '0;
    end else if (fire) begin
      rd_pos_q <= mem_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  // Falling-edge copy models presentation on the falling clock edge.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) rd_neg_q <= '0;
    else        rd_neg_q <= rd_pos_q;
  end

  assign rd_data = cfg.rise ? rd_pos_q : rd_neg_q;
  assign valid_n = ~vld_q;

endmodule

// File: rtl/burst_rd_seq.sv
module burst_rd_seq
  import burst_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [15:0]   cfg_wdata,
  input  logic          addr_latch,
  input  logic [AW-1:0] start_addr,
  output logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] rd_data,
  output logic          valid_n,
  output logic          cfg_err
);

  logic [1:0]    rst_sync_q;
  logic          rst_n_s;
  burst_cfg_t    cfg_q;
  logic          load, active, fire, pre, last;
  logic [2:0]    beat_k;
  logic [AW-1:0] start_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  burst_cfg_reg u_cfg (
    .clk   (clk),
    .rst_n (rst_n_s),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .cfg   (cfg_q),
    .err   (cfg_err)
  );

  burst_seq_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .cfg      (cfg_q),
    .latch_in (addr_latch),
    .load     (load),
    .active   (active),
    .fire     (fire),
    .pre      (pre),
    .last     (last),
    .beat_k   (beat_k)
  );

  burst_addr_gen #(.AW(AW)) u_addr (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .cfg        (cfg_q),
    .load       (load),
    .fire       (fire),
    .last       (last),
    .beat_k     (beat_k),
    .start_addr (start_addr),
    .start_q    (start_q),
    .addr       (mem_addr)
  );

  burst_out_stage #(.DW(DW)) u_out (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .cfg       (cfg_q),
    .fire      (fire),
    .pre       (pre),
    .mem_rdata (mem_rdata),
    .rd_data   (rd_data),
    .valid_n   (valid_n)
  );

endmodule

// File: rtl/burst_rd_seq_chk.sv
module burst_rd_seq_chk
  import burst_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input burst_cfg_t    cfg,
  input logic          cfg_err,
  input logic          active,
  input logic          fire,
  input logic [2:0]    beat_k,
  input logic [AW-1:0] start_q,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] rd_data,
  input logic          valid_n
);

  logic [AW-1:0] blk_mask;
  logic          cont;

  assign cont     = (cfg.len == LEN_CONT);
  assign blk_mask = {{(AW-3){1'b0}}, len_mask(cfg.len)};

  assert_async_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg.async) |-> valid_n);

  assert_err_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_err) |-> cfg_err);

  assert_space_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.space2 && fire) |=> !fire);

  assert_block_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !cont && (!cfg.seq || !cfg.nowrap)) |->
      ((mem_addr & ~blk_mask) == (start_q & ~blk_mask)));

  assert_len_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !cont) |-> (beat_k <= len_mask(cfg.len)));

  assert_data_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg.early && !$stable(rd_data)) |-> !valid_n);

endmodule

bind burst_rd_seq burst_rd_seq_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n_s),
  .cfg      (cfg_q),
  .cfg_err  (cfg_err),
  .active   (active),
  .fire     (fire),
  .beat_k   (beat_k),
  .start_q  (start_q),
  .mem_addr (mem_addr),
  .rd_data  (rd_data),
  .valid_n  (valid_n)
);

// File: tb/burst_rd_seq_tb.sv
`timescale 1ns/1ps
module burst_rd_seq_tb;

  localparam int AW = 20;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_we;
  logic [15:0]   cfg_wdata;
  logic          addr_latch;
  logic [AW-1:0] start_addr;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_rdata;
  logic [DW-1:0] rd_data;
  logic          valid_n;
  logic          cfg_err;

  int            n_chk = 0;
  int            n_fail = 0;
  logic [DW-1:0] d_early;
  logic [DW-1:0] prev_data;

  always #4 clk = ~clk;

  function automatic logic [DW-1:0] memf(input logic [AW-1:0] a);
    return a[15:0] * 16'd7 + 16'h1234;
  endfunction

  assign mem_rdata = memf(mem_addr);

  burst_rd_seq #(.AW(AW), .DW(DW)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_wdata  (cfg_wdata),
    .addr_latch (addr_latch),
    .start_addr (start_addr),
    .mem_addr   (mem_addr),
    .mem_rdata  (mem_rdata),
    .rd_data    (rd_data),
    .valid_n    (valid_n),
    .cfg_err    (cfg_err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2 d_early = rd_data;
    #4;
  endtask

  function automatic logic [15:0] mkw(input bit as, input logic [2:0] lat,
      input bit sp, input bit er, input bit sq, input bit ri, input bit nw,
      input logic [2:0] ln);
    logic [15:0] w;
    w = '0;
    w[15] = as; w[13:11] = lat; w[9] = sp; w[8] = er;
    w[7] = sq; w[6] = ri; w[3] = nw; w[2:0] = ln;
    return w;
  endfunction

  // Expected address of beat k (N == 0 means continuous).
  function automatic logic [AW-1:0] aexp(input int s, input int k, input int n,
                                         input bit sq, input bit nw);
    int off, base;
    if (n == 0 || (sq && nw)) return AW'(s + k);
    off  = s % n;
    base = s - off;
    if (sq) return AW'(base + ((off + k) % n));
    return AW'(base + (off ^ k));
  endfunction

  task automatic run(input logic [15:0] w, input int lat, input int n, input int sp,
                     input bit er, input bit sq, input bit nw, input bit ri,
                     input int s, input int hold);
    int b, lim;
    bit beat_now, beat_next;
    logic [AW-1:0] ea;
    logic [DW-1:0] ed, ede;
    cfg_we = 1'b1; cfg_wdata = w;
    step();
    cfg_we = 1'b0; addr_latch = 1'b0;
    step();
    addr_latch = 1'b1; start_addr = AW'(s);
    for (int t = 0; t <= hold + 3; t++) begin
      step();
      lim = (t < hold) ? t : hold;
      b = 0; beat_now = 0; beat_next = 0;
      for (int k = 0; (n == 0 || k < n) && (lat + k*sp <= hold + 1); k++) begin
        if (lat + k*sp <= lim) b = k + 1;
        if (lat + k*sp == t && t <= hold) beat_now = 1;
        if (lat + k*sp == t + 1 && t + 1 <= hold) beat_next = 1;
      end
      if (n == 0)     ea = aexp(s, b, n, sq, nw);
      else if (b < n) ea = aexp(s, b, n, sq, nw);
      else            ea = aexp(s, n - 1, n, sq, nw);
      ed  = (b > 0) ? memf(aexp(s, b - 1, n, sq, nw)) : prev_data;
      ede = ri ? ed : ((b > 1) ? memf(aexp(s, b - 2, n, sq, nw)) : prev_data);
      // R2 R4 R5 R8: strobe cycle of each beat
      chk(valid_n == (er ? !beat_next : !beat_now), er ? "R5" : "R2/R4",
          "valid_n", valid_n, er ? !beat_next : !beat_now);
      // R6 R7 R9: word address order
      chk(mem_addr == ea, sq ? "R7" : "R6", "mem_addr", mem_addr, ea);
      // R11: data word of the latest beat
      chk(rd_data == ed, "R11", "rd_data", rd_data, ed);
      // R10: edge on which data appears
      if (beat_now) chk(d_early == ede, "R10", "rd_data at rising edge", d_early, ede);
      if (t == hold) addr_latch = 1'b0;
    end
    prev_data = ed;
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int idx;
    bit er, ri;
    int s;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0; addr_latch = 1'b0; start_addr = '0;
    prev_data = '0;
    step(); step();
    chk(valid_n == 1'b1, "R1", "reset valid_n", valid_n, 1);
    chk(rd_data == '0, "R1", "reset rd_data", rd_data, 0);
    chk(mem_addr == '0, "R1", "reset mem_addr", mem_addr, 0);
    chk(cfg_err == 1'b0, "R3", "reset cfg_err", cfg_err, 0);
    rst_n = 1'b1;
    step(); step(); step();

    // R1: latch ignored in the asynchronous reset mode
    addr_latch = 1'b1; start_addr = 20'h00055;
    for (int t = 0; t < 14; t++) begin
      step();
      chk(valid_n == 1'b1, "R1", "async valid_n", valid_n, 1);
      chk(rd_data == '0, "R1", "async rd_data", rd_data, 0);
      chk(mem_addr == '0, "R1", "async mem_addr", mem_addr, 0);
    end
    addr_latch = 1'b0;
    step();

    idx = 0;
    for (int lc = 2; lc <= 6; lc++)
      for (int sp = 0; sp <= 1; sp++)
        for (int sq = 0; sq <= 1; sq++)
          for (int nw = 0; nw <= 1; nw++)
            for (int li = 0; li <= 1; li++) begin
              er = idx[0] ^ idx[2];
              ri = idx[1];
              s  = 32'h3A000 + idx * 29;
              run(mkw(0, 3'(lc), sp[0], er, sq[0], ri, nw[0], li ? 3'b010 : 3'b001),
                  lc + 2, li ? 8 : 4, sp + 1, er, sq[0], nw[0], ri, s,
                  lc + 2 + (li ? 8 : 4) * (sp + 1) + 2);
              idx++;
            end
    chk(cfg_err == 1'b0, "R3", "cfg_err after valid writes", cfg_err, 0);

    // R3: reserved latency code keeps 8; length field takes 4
    run(mkw(0, 3'b000, 0, 0, 1, 1, 0, 3'b001), 8, 4, 1, 0, 1, 0, 1, 32'h00106, 14);
    chk(cfg_err == 1'b1, "R3", "cfg_err after reserved latency", cfg_err, 1);
    // R3: reserved length code keeps 4; latency takes 5
    run(mkw(0, 3'b011, 1, 0, 0, 0, 0, 3'b100), 5, 4, 2, 0, 0, 0, 0, 32'h00203, 15);
    chk(cfg_err == 1'b1, "R3", "cfg_err sticky", cfg_err, 1);
    // R3: reserved code 111 in the latency field
    run(mkw(0, 3'b111, 0, 1, 1, 1, 1, 3'b010), 5, 8, 1, 1, 1, 1, 1, 32'h00307, 15);
    chk(cfg_err == 1'b1, "R3", "cfg_err still set", cfg_err, 1);

    // R9: continuous bursts, ended by dropping the strobe
    run(mkw(0, 3'b011, 0, 0, 1, 1, 0, 3'b111), 5, 0, 1, 0, 1, 0, 1, 32'h0FFFD, 20);
    run(mkw(0, 3'b100, 1, 0, 0, 0, 0, 3'b111), 6, 0, 2, 0, 0, 0, 0, 32'h00412, 17);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule